// File: doc/BRIEF.md
# Indexed Codec Control Register File

This block is the control-register front end of an audio codec. A host reaches it over a small word-addressed bus that spans a 64-byte window. Bits [5:2] of the byte address pick one of sixteen 32-bit direct registers. Two of those registers form an index/data pair. Direct register 0 holds a pointer. Direct register 1 is a port that reads and writes one of thirty-two 8-bit indirect registers, chosen by that pointer.

Several slots follow special rules. Some are read-only, one is write-only and one is only partly writable, and the reset values include two fixed version codes. A write to the control register with bit 0 set starts a soft reset. The soft reset uses the same clear-and-load path as the hardware reset. After the soft reset, the written value stays in the control register. The interrupt output is present for pin compatibility and never asserts.

Requests arrive on a valid/ready channel, and read data leaves on a second valid/ready channel. When the host holds `rsp_ready` low, a pending response stays frozen. While that response is pending, the block refuses new requests, so back-pressure reaches the host in the same cycle.

Top module: `ccr_codec_ctrl`

## Requirements
- R1: After hardware reset, every direct register reads 0. Indirect 12 reads 0x8A, indirect 25 reads 0xA0, and every other indirect register reads 0.
- R2: Direct registers other than 1, 2 and 4 store and return all 32 written bits. The register number is bits [5:2] of the byte address, and bits [1:0] are ignored.
- R3: The indirect index is bits [4:0] of direct register 0, and direct register 0 itself keeps all 32 bits. A write to direct register 1 stores bits [7:0] of the data into the indexed register. A read of direct register 1 returns that register zero-extended.
- R4: Indirect index 3 accepts writes, but a read of it through the data port always returns 0.
- R5: Data-port writes to indirect indices 11 and 25 leave them unchanged.
- R6: A data-port write to indirect index 12 stores (data & 0x40) | 0x8A.
- R7: Writes to direct register 2 are ignored, and it always reads 0.
- R8: A write to direct register 4 stores the data masked to bits [6:0]. If bit 0 of the data is 1, all other direct and indirect registers first return to their R1 values in the same cycle, and the register-4 store wins over the clear.
- R9: `req_ready` equals `!rsp_valid || rsp_ready`. An accepted read raises `rsp_valid` on the next cycle with its data. `rsp_valid` and `rsp_rdata` hold steady while `rsp_ready` is low.
- R10: `irq` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Byte address in the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Host takes read data |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Interrupt, held low |

## Verification
The bench builds the block with its default parameters: sixteen 32-bit direct registers and thirty-two 8-bit indirect registers. With these values every special indirect slot (3, 11, 12 and 25) is reachable, as well as the top index 31 and the highest byte address. The 5-bit index field sits inside a 32-bit pointer, so writing all-ones in the upper bits confirms that only the low bits select. A stalled response channel checks that back-pressure freezes the data and blocks new requests.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam logic [7:0] CCR_CODEC_VER = 8'h8A;
  localparam logic [7:0] CCR_CHIP_VER  = 8'hA0;

  typedef enum logic [1:0] {
    SLOT_PLAIN,
    SLOT_WRITE_ONLY,
    SLOT_READ_ONLY,
    SLOT_VERSION
  } slot_kind_e;
endpackage

// File: rtl/ccr_req_port.sv
module ccr_req_port #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  localparam int SEL_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              wr_fire,
  output logic [SEL_W-1:0]  sel,
  output logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rd_data
);
  logic accept;
  logic rd_fire;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_fire   = accept && req_write;
  assign rd_fire   = accept && !req_write;
  assign sel       = req_addr[ADDR_W-1:2];
  assign wdata     = req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (rd_fire) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rd_data;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ccr_direct_file.sv
module ccr_direct_file #(
  parameter int NUM_DIR     = 16,
  parameter int DATA_W      = 32,
  parameter int INDEX_REG   = 0,
  parameter int PORT_REG    = 1,
  parameter int RO_REG      = 2,
  parameter int CTRL_REG    = 4,
  parameter int CTRL_KEEP_W = 7,
  localparam int SEL_W = $clog2(NUM_DIR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] index_q
);
  localparam logic [DATA_W-1:0] CTRL_MASK = {{(DATA_W-CTRL_KEEP_W){1'b0}}, {CTRL_KEEP_W{1'b1}}};

  logic [DATA_W-1:0] q [NUM_DIR];

  for (genvar i = 0; i < NUM_DIR; i++) begin : g_reg
    if (i == PORT_REG || i == RO_REG) begin : g_none
      assign q[i] = '0;
    end else if (i == CTRL_REG) begin : g_ctrl
      logic [DATA_W-1:0] r;
      always_ff @(posedge clk) begin
        if (!rst_n)                                  r <= '0;
        else if (wr_en && wr_sel == SEL_W'(i))       r <= wdata & CTRL_MASK;
        else if (clear)                              r <= '0;
      end
      assign q[i] = r;
    end else begin : g_plain
      logic [DATA_W-1:0] r;
      always_ff @(posedge clk) begin
        if (!rst_n)                                  r <= '0;
        else if (wr_en && wr_sel == SEL_W'(i))       r <= wdata;
        else if (clear)                              r <= '0;
      end
      assign q[i] = r;
    end
  end

  assign rd_data = q[rd_sel];
  assign index_q = q[INDEX_REG];
endmodule

// File: rtl/ccr_indirect_bank.sv
module ccr_indirect_bank
  import ccr_pkg::*;
#(
  parameter int          NUM_IND   = 32,
  parameter int          IND_W     = 8,
  parameter int          WO_IDX    = 3,
  parameter int          RO_IDX    = 11,
  parameter int          VER_IDX   = 12,
  parameter int          CHIP_IDX  = 25,
  parameter logic [7:0]  VER_KEEP  = 8'h40,
  localparam int IDX_W = $clog2(NUM_IND)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [IND_W-1:0] wdata,
  output logic [IND_W-1:0] rd_data
);
  function automatic slot_kind_e kind_of(int n);
    if (n == WO_IDX)                     return SLOT_WRITE_ONLY;
    if (n == RO_IDX || n == CHIP_IDX)    return SLOT_READ_ONLY;
    if (n == VER_IDX)                    return SLOT_VERSION;
    return SLOT_PLAIN;
  endfunction

  function automatic logic [IND_W-1:0] init_of(int n);
    if (n == VER_IDX)  return IND_W'(CCR_CODEC_VER);
    if (n == CHIP_IDX) return IND_W'(CCR_CHIP_VER);
    return '0;
  endfunction

  logic [IND_W-1:0] q [NUM_IND];

  for (genvar j = 0; j < NUM_IND; j++) begin : g_slot
    localparam slot_kind_e KIND = kind_of(j);
    localparam logic [IND_W-1:0] INIT = init_of(j);
    logic hit;
    logic [IND_W-1:0] r;
    assign hit = wr_en && idx == IDX_W'(j);
    if (KIND == SLOT_READ_ONLY) begin : g_ro
      always_ff @(posedge clk) begin
        if (!rst_n || clear) r <= INIT;
      end
    end else if (KIND == SLOT_VERSION) begin : g_ver
      always_ff @(posedge clk) begin
        if (!rst_n || clear) r <= INIT;
        else if (hit)        r <= (wdata & IND_W'(VER_KEEP)) | IND_W'(CCR_CODEC_VER);
      end
    end else begin : g_rw
      always_ff @(posedge clk) begin
        if (!rst_n || clear) r <= INIT;
        else if (hit)        r <= wdata;
      end
    end
    assign q[j] = r;
  end

  assign rd_data = (idx == IDX_W'(WO_IDX)) ? '0 : q[idx];
endmodule

// File: rtl/ccr_codec_ctrl.sv
module ccr_codec_ctrl #(
  parameter int NUM_DIR     = 16,
  parameter int DATA_W      = 32,
  parameter int NUM_IND     = 32,
  parameter int IND_W       = 8,
  parameter int INDEX_REG   = 0,
  parameter int PORT_REG    = 1,
  parameter int RO_REG      = 2,
  parameter int CTRL_REG    = 4,
  parameter int CTRL_KEEP_W = 7,
  parameter int WO_IDX      = 3,
  localparam int SEL_W  = $clog2(NUM_DIR),
  localparam int ADDR_W = SEL_W + 2,
  localparam int IDX_W  = $clog2(NUM_IND)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq
);
  logic              wr_fire;
  logic [SEL_W-1:0]  sel;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rd_data;
  logic [DATA_W-1:0] dir_rd;
  logic [DATA_W-1:0] index_q;
  logic [IND_W-1:0]  ind_rd;
  logic [IDX_W-1:0]  ind_idx;
  logic              soft_clear;
  logic              port_wr;

  ccr_req_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .wr_fire(wr_fire), .sel(sel), .wdata(wdata), .rd_data(rd_data)
  );

  assign soft_clear = wr_fire && sel == SEL_W'(CTRL_REG) && wdata[0];
  assign port_wr    = wr_fire && sel == SEL_W'(PORT_REG);
  assign ind_idx    = index_q[IDX_W-1:0];

  ccr_direct_file #(
    .NUM_DIR(NUM_DIR), .DATA_W(DATA_W), .INDEX_REG(INDEX_REG), .PORT_REG(PORT_REG),
    .RO_REG(RO_REG), .CTRL_REG(CTRL_REG), .CTRL_KEEP_W(CTRL_KEEP_W)
  ) u_dir (
    .clk(clk), .rst_n(rst_n), .clear(soft_clear),
    .wr_en(wr_fire), .wr_sel(sel), .wdata(wdata),
    .rd_sel(sel), .rd_data(dir_rd), .index_q(index_q)
  );

  ccr_indirect_bank #(
    .NUM_IND(NUM_IND), .IND_W(IND_W), .WO_IDX(WO_IDX)
  ) u_ind (
    .clk(clk), .rst_n(rst_n), .clear(soft_clear),
    .wr_en(port_wr), .idx(ind_idx), .wdata(wdata[IND_W-1:0]),
    .rd_data(ind_rd)
  );

  assign rd_data = (sel == SEL_W'(PORT_REG)) ? {{(DATA_W-IND_W){1'b0}}, ind_rd} : dir_rd;
  assign irq     = 1'b0;
endmodule

// File: rtl/ccr_codec_ctrl_chk.sv
module ccr_codec_ctrl_chk #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 32,
  parameter int IDX_W       = 5,
  parameter int PORT_REG    = 1,
  parameter int RO_REG      = 2,
  parameter int CTRL_REG    = 4,
  parameter int CTRL_KEEP_W = 7,
  parameter int WO_IDX      = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              irq,
  input logic [IDX_W-1:0]  idx
);
  logic rd_acc;
  assign rd_acc = req_valid && req_ready && !req_write;

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));
  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);
  // R9
  read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid);
  // R10
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n) !irq);
  // R7
  ro_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc && req_addr[ADDR_W-1:2] == (ADDR_W-2)'(RO_REG) |=> rsp_rdata == '0);
  // R8
  ctrl_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc && req_addr[ADDR_W-1:2] == (ADDR_W-2)'(CTRL_REG) |=> rsp_rdata[DATA_W-1:CTRL_KEEP_W] == '0);
  // R4
  write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc && req_addr[ADDR_W-1:2] == (ADDR_W-2)'(PORT_REG) && idx == IDX_W'(WO_IDX) |=> rsp_rdata == '0);
endmodule

bind ccr_codec_ctrl ccr_codec_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .PORT_REG(PORT_REG),
  .RO_REG(RO_REG), .CTRL_REG(CTRL_REG), .CTRL_KEEP_W(CTRL_KEEP_W), .WO_IDX(WO_IDX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .irq(irq), .idx(ind_idx)
);

// File: tb/sim_ccr_codec_ctrl.sv
module sim_ccr_codec_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        irq;

  always #4 clk = ~clk;

  ccr_codec_ctrl #(.NUM_DIR(16), .DATA_W(32), .NUM_IND(32), .IND_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  logic [31:0] exp_q[$];
  string       tag_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  int irq_seen = 0;
  bit done = 0;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(bit wr, logic [5:0] addr, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = d;
    forever begin
      #1;
      if (req_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic wr(logic [5:0] addr, logic [31:0] d);
    send(1'b1, addr, d);
  endtask

  task automatic rd(logic [5:0] addr, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    send(1'b0, addr, '0);
  endtask

  task automatic wr_ind(logic [4:0] i, logic [7:0] d);
    wr(6'h00, {27'd0, i});
    wr(6'h04, {24'd0, d});
  endtask

  task automatic rd_ind(logic [4:0] i, logic [31:0] exp, string tag);
    wr(6'h00, {27'd0, i});
    rd(6'h04, exp, tag);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (irq !== 1'b0) irq_seen++;
      if (rst_n && rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected response", rsp_rdata, 32'h0);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rsp_rdata === e, t, rsp_rdata, e);
        end
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(req_ready === 1'b1 && rsp_valid === 1'b0, "R1 idle after reset",
          {30'd0, req_ready, rsp_valid}, 32'h2);
    for (int i = 0; i < 16; i++) rd(6'(i * 4), 32'h0, "R1 direct reset value");
    rd_ind(5'd12, 32'h8A, "R1 codec version");
    rd_ind(5'd25, 32'hA0, "R1 chip version");
    rd_ind(5'd31, 32'h0, "R1 indirect 31 reset");

    // R2 plain direct storage
    wr(6'h14, 32'hDEADBEEF);
    rd(6'h14, 32'hDEADBEEF, "R2 reg5 readback");
    wr(6'h3F, 32'h13579BDF);
    rd(6'h3C, 32'h13579BDF, "R2 reg15 via low-bit address");

    // R3 index/data pair
    wr(6'h00, 32'hFFFFFFE7);
    wr(6'h04, 32'h000001A5);
    rd(6'h04, 32'hA5, "R3 data port index 7");
    rd(6'h00, 32'hFFFFFFE7, "R3 pointer full width");
    wr_ind(5'd31, 8'h3C);
    rd_ind(5'd31, 32'h3C, "R3 index 31");

    // R4 write-only slot
    wr_ind(5'd3, 8'h55);
    rd_ind(5'd3, 32'h0, "R4 index 3 reads zero");

    // R5 read-only slots
    wr_ind(5'd11, 8'h77);
    rd_ind(5'd11, 32'h0, "R5 index 11 unchanged");
    wr_ind(5'd25, 8'h12);
    rd_ind(5'd25, 32'hA0, "R5 index 25 unchanged");

    // R6 partly writable version
    wr_ind(5'd12, 8'h00);
    rd_ind(5'd12, 32'h8A, "R6 version write 00");
    wr_ind(5'd12, 8'hFF);
    rd_ind(5'd12, 32'hCA, "R6 version write FF");

    // R7 read-only direct
    wr(6'h08, 32'h00001234);
    rd(6'h08, 32'h0, "R7 reg2 ignores write");

    // R8 control register
    wr(6'h10, 32'h00000012);
    rd(6'h10, 32'h12, "R8 ctrl store no reset");
    rd(6'h14, 32'hDEADBEEF, "R8 no reset keeps reg5");
    wr_ind(5'd7, 8'h5A);
    wr(6'h10, 32'hFFFFFF03);
    rd(6'h10, 32'h03, "R8 ctrl keeps masked value");
    rd(6'h14, 32'h0, "R8 soft reset clears reg5");
    rd(6'h3C, 32'h0, "R8 soft reset clears reg15");
    rd(6'h00, 32'h0, "R8 soft reset clears pointer");
    rd_ind(5'd12, 32'h8A, "R8 soft reset reloads version");
    rd_ind(5'd7, 32'h0, "R8 soft reset clears indirect 7");
    rd_ind(5'd25, 32'hA0, "R8 soft reset chip version");

    // R9 back-pressure
    wr(6'h18, 32'hCAFEF00D);
    @(negedge clk);
    rsp_ready = 1'b0;
    rd(6'h18, 32'hCAFEF00D, "R9 stalled read data");
    @(negedge clk);
    #1;
    check(rsp_valid === 1'b1, "R9 response pending", {31'd0, rsp_valid}, 32'h1);
    check(req_ready === 1'b0, "R9 ready low under stall", {31'd0, req_ready}, 32'h0);
    repeat (3) @(negedge clk);
    #1;
    check(rsp_rdata === 32'hCAFEF00D && rsp_valid === 1'b1, "R9 held during stall",
          rsp_rdata, 32'hCAFEF00D);
    rsp_ready = 1'b1;
    rd(6'h18, 32'hCAFEF00D, "R9 read after stall");

    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, "R9 all responses returned", exp_q.size(), 32'h0);
    // R10
    check(irq_seen == 0, "R10 irq never high", irq_seen, 32'h0);
    done = 1;
    summary();
    $finish;
  end
endmodule